// File: doc/BRIEF.md
# Stop-Mode Wake Stabilization Controller

This block supervises the exit from a clock-stop low-power state. A stop request turns the oscillator off and withholds the CPU clock. Only an external wake interrupt turns the oscillator back on. After that a cascaded 8-bit prescaler and 8-bit timer count down on the restarted clock. The CPU clock enable stays low until the timer underflows, which gives the resonator time to settle.

On wake the counters are normally loaded with fixed settle values: timer 0x01 and prescaler 0xFF. A control bit can inhibit that load. The counters then run from the values software wrote before stopping. Software programs the prescaler, the timer and the inhibit bit through a small write port. That port is honoured only while the controller is running.

Top module: `wake_stab_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the controller is running. `osc_en_o` and `cpu_clk_en_o` are both 1 and the inhibit bit is 0.
- R2: A `stop_req_i` sampled while running sets both `osc_en_o` and `cpu_clk_en_o` to 0 from the next clock edge.
- R3: Once stopped, only `wake_irq_i` ends the stop. At the edge that samples it, `osc_en_o` returns to 1 and `cpu_clk_en_o` stays 0 (stabilizing).
- R4: With the inhibit bit at 0, wake loads timer 0x01 and prescaler 0xFF. The reload values are set to the same figures. `cpu_clk_en_o` therefore stays low for exactly (1+1)*(255+1) = 512 cycles after the wake edge.
- R5: With the inhibit bit at 1, the counters keep their programmed values. The gated window lasts (T+1)*(P+1) cycles, where T is the programmed timer value and P the programmed prescaler value. The smallest case is T=P=0, which gives 1 cycle.
- R6: The prescaler counts down once per cycle while stabilizing. When it steps from 0 it reloads from its reload value and moves the timer by one. When the timer is decremented from 0x00 it underflows and reloads from its reload value. That underflow sets `cpu_clk_en_o` at the same edge and the controller is running again. Repeated inhibited stops without rewrites give the same window.
- R7: A stop request is ignored while stopped or stabilizing. A wake interrupt is ignored while running or stabilizing.
- R8: Register writes are ignored unless the controller is running.
- R9: Write select encoding: 0 writes the prescaler value and its reload value, 1 writes the timer value and its reload value, and 2 writes the inhibit bit from data bit 0. Select 3 has no effect.
- R10: Writing 0 to the inhibit bit restores the fixed load on the next wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| stop_req_i | input | 1 | Stop command |
| wake_irq_i | input | 1 | External wake interrupt |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select (0 prescaler, 1 timer, 2 control) |
| wr_data_i | input | 8 | Write data |
| osc_en_o | output | 1 | Oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |

## Verification
The bench measures the exact length of the gated window for four cases: the fixed load, an inhibited load, the one-cycle case with both counters at zero, and the 256-cycle case with a zero prescaler. A design that mishandles the prescaler reload or treats reaching zero as the underflow releases the CPU clock early or late by whole prescaler periods. The bench also issues stop requests, wake pulses and writes in the states where they must be ignored. A design that honours them would restart the count, shorten the window, or leave the oscillator on. Finally it repeats an inhibited stop without rewriting the counters, which exposes a design that does not restore the counters from their reload values.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_SETTLE = 2'd2
  } wake_state_e;

  localparam logic [1:0] SEL_PRE  = 2'd0;
  localparam logic [1:0] SEL_TMR  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
endpackage

// File: rtl/wake_rst_sync.sv
module wake_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
  import wake_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_req_i,
  input  logic wake_irq_i,
  input  logic uflow_i,
  output logic run_o,
  output logic load_o,
  output logic count_en_o,
  output logic osc_en_o,
  output logic cpu_clk_en_o
);
  wake_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (stop_req_i) state_d = ST_STOP;
      ST_STOP:   if (wake_irq_i) state_d = ST_SETTLE;
      ST_SETTLE: if (uflow_i)    state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign run_o        = (state_q == ST_RUN);
  assign load_o       = (state_q == ST_STOP) && wake_irq_i;
  assign count_en_o   = (state_q == ST_SETTLE);
  assign osc_en_o     = (state_q != ST_STOP);
  assign cpu_clk_en_o = (state_q == ST_RUN);

  // R2: stop while running halts oscillator
  p_stop_halts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) && stop_req_i |=> !osc_en_o && !cpu_clk_en_o);
  // R3: only wake leaves STOPPED
  p_stop_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) && !wake_irq_i |=> (state_q == ST_STOP));
  // R7: wake ignored while running
  p_wake_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) && !stop_req_i |=> (state_q == ST_RUN));
  // R7: stop ignored while settling
  p_settle_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETTLE) && !uflow_i |=> (state_q == ST_SETTLE));
endmodule

// File: rtl/wake_cascade.sv
module wake_cascade
  import wake_pkg::*;
#(
  parameter int          CNT_W    = 8,
  parameter logic [CNT_W-1:0] PRE_AUTO = 8'hFF,
  parameter logic [CNT_W-1:0] TMR_AUTO = 8'h01
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ok_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             load_i,
  input  logic             count_en_i,
  output logic             uflow_o
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] pre_cnt_q, pre_cnt_d, pre_rld_q, pre_rld_d;
  logic [CNT_W-1:0] tmr_cnt_q, tmr_cnt_d, tmr_rld_q, tmr_rld_d;
  logic             inhibit_q, inhibit_d;
  logic             pre_zero, tmr_zero;

  assign pre_zero = (pre_cnt_q == ZERO);
  assign tmr_zero = (tmr_cnt_q == ZERO);
  assign uflow_o  = count_en_i && pre_zero && tmr_zero;

  always_comb begin
    pre_cnt_d = pre_cnt_q;
    pre_rld_d = pre_rld_q;
    tmr_cnt_d = tmr_cnt_q;
    tmr_rld_d = tmr_rld_q;
    inhibit_d = inhibit_q;
    if (wr_ok_i) begin
      unique case (wr_sel_i)
        SEL_PRE:  begin pre_cnt_d = wr_data_i; pre_rld_d = wr_data_i; end
        SEL_TMR:  begin tmr_cnt_d = wr_data_i; tmr_rld_d = wr_data_i; end
        SEL_CTRL: inhibit_d = wr_data_i[0];
        default:  ;
      endcase
    end else if (load_i && !inhibit_q) begin
      pre_cnt_d = PRE_AUTO;
      pre_rld_d = PRE_AUTO;
      tmr_cnt_d = TMR_AUTO;
      tmr_rld_d = TMR_AUTO;
    end else if (count_en_i) begin
      if (pre_zero) begin
        pre_cnt_d = pre_rld_q;
        tmr_cnt_d = tmr_zero ? tmr_rld_q : (tmr_cnt_q - ONE);
      end else begin
        pre_cnt_d = pre_cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt_q <= PRE_AUTO;
      pre_rld_q <= PRE_AUTO;
      tmr_cnt_q <= TMR_AUTO;
      tmr_rld_q <= TMR_AUTO;
      inhibit_q <= 1'b0;
    end else begin
      pre_cnt_q <= pre_cnt_d;
      pre_rld_q <= pre_rld_d;
      tmr_cnt_q <= tmr_cnt_d;
      tmr_rld_q <= tmr_rld_d;
      inhibit_q <= inhibit_d;
    end
  end

  // R4: fixed values loaded on wake
  p_autoload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !inhibit_q && !wr_ok_i |=> (tmr_cnt_q == TMR_AUTO) && (pre_cnt_q == PRE_AUTO));
  // R5: inhibited wake keeps counters
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && inhibit_q && !wr_ok_i |=> $stable(tmr_cnt_q) && $stable(pre_cnt_q));
  // R6: prescaler step from zero reloads
  p_pre_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_en_i && pre_zero |=> (pre_cnt_q == $past(pre_rld_q)));
  // R8: counters untouched while stopped without wake
  p_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ok_i && !load_i && !count_en_i |=> $stable(tmr_cnt_q) && $stable(pre_cnt_q) && $stable(inhibit_q));
endmodule

// File: rtl/wake_stab_ctrl.sv
module wake_stab_ctrl
  import wake_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_req_i,
  input  logic             wake_irq_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             osc_en_o,
  output logic             cpu_clk_en_o
);
  logic rst_n_s, run, load, count_en, uflow;

  wake_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_s)
  );

  wake_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_s),
    .stop_req_i   (stop_req_i),
    .wake_irq_i   (wake_irq_i),
    .uflow_i      (uflow),
    .run_o        (run),
    .load_o       (load),
    .count_en_o   (count_en),
    .osc_en_o     (osc_en_o),
    .cpu_clk_en_o (cpu_clk_en_o)
  );

  wake_cascade #(.CNT_W(CNT_W)) u_casc (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .wr_ok_i    (wr_en_i && run),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .load_i     (load),
    .count_en_i (count_en),
    .uflow_o    (uflow)
  );

  // R6: CPU clock returns only after a timer underflow
  p_release_on_uflow_r6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $rose(cpu_clk_en_o) |-> $past(uflow));
  // R1: reset state
  p_reset_run_r1: assert property (@(posedge clk_i)
    !rst_n_s |-> osc_en_o && cpu_clk_en_o);
endmodule

// File: tb/wake_stab_ctrl_tb.sv
module wake_stab_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       stop_req, wake_irq, wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic       osc_en, cpu_en;

  int total = 0;
  int fails = 0;
  int exp_q[$];
  int gcnt = 0;

  always #5 clk = ~clk;

  wake_stab_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stop_req_i(stop_req), .wake_irq_i(wake_irq),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .osc_en_o(osc_en), .cpu_clk_en_o(cpu_en)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures each gated window and compares with scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (osc_en && !cpu_en) gcnt++;
      else if (cpu_en && gcnt > 0) begin
        if (exp_q.size() == 0) check("R6 unexpected window", gcnt, -1);
        else check("R4/R5/R6 gated window", gcnt, exp_q.pop_front());
        gcnt = 0;
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
  endtask

  // driver: stop, optional disturbances, wake; pushes expected window length
  task automatic stop_wake(input int exp_n, input bit disturb);
    pulse_stop();
    check("R2 osc_en after stop", osc_en, 0);
    check("R2 cpu_en after stop", cpu_en, 0);
    pulse_stop();
    check("R7 stop ignored while stopped", osc_en, 0);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    check("R3 no wake stays stopped", osc_en, 0);
    @(negedge clk); wake_irq = 1'b1; exp_q.push_back(exp_n);
    @(negedge clk); wake_irq = 1'b0;
    check("R3 osc on after wake", osc_en, 1);
    if (exp_n > 1) check("R3 cpu gated after wake", cpu_en, 0);
    if (disturb && exp_n > 4) begin
      stop_req = 1'b1; wake_irq = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h00;
      @(negedge clk);
      stop_req = 1'b0; wake_irq = 1'b0; wr_en = 1'b0;
      check("R7 stop ignored while settling", osc_en, 1);
    end
    while (!cpu_en) @(negedge clk);
    @(negedge clk);
    check("R6 running after window", {osc_en, cpu_en}, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; stop_req = 1'b0; wake_irq = 1'b0; wr_en = 1'b0;
    wr_sel = 2'd0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 osc_en in reset", osc_en, 1);
    check("R1 cpu_en in reset", cpu_en, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 running after reset", {osc_en, cpu_en}, 3);

    // R7: wake while running ignored
    @(negedge clk); wake_irq = 1'b1;
    @(negedge clk); wake_irq = 1'b0;
    check("R7 wake ignored in run", {osc_en, cpu_en}, 3);

    // R4: default fixed load, inhibit resets to 0 (R1); writes in STOPPED ignored (R8)
    stop_wake(512, 1'b0);

    // R5/R9: pre=3 (sel 0), tmr=2 (sel 1), inhibit (sel 2 bit0) -> 3*4 = 12
    wr(2'd0, 8'd3);
    wr(2'd1, 8'd2);
    wr(2'd2, 8'h01);
    stop_wake(12, 1'b0);
    // R6: repeat without rewrite; R7/R8 disturbances while settling
    stop_wake(12, 1'b1);
    // R9: select 3 has no effect
    wr(2'd3, 8'h00);
    stop_wake(12, 1'b0);
    // R5: smallest window
    wr(2'd0, 8'd0);
    wr(2'd1, 8'd0);
    stop_wake(1, 1'b0);
    // R5: zero prescaler, full timer -> 256
    wr(2'd1, 8'hFF);
    stop_wake(256, 1'b1);
    // R10: clear inhibit (other data bits set) -> fixed load again
    wr(2'd2, 8'hFE);
    stop_wake(512, 1'b1);

    repeat (3) @(negedge clk);
    check("R6 scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule